// File: doc/BRIEF.md
# FPGA Configuration Byte Streamer

This block loads a configuration image into a slave FPGA over a byte-wide write port, with no processor involved. After reset it pulses the target's active-low program line and waits for the target to report that it is ready. It then writes a fixed eight-byte header, followed by framed chunks of payload taken from a ready/valid byte source. Each chunk of 21 payload bytes is wrapped in a start code, a check code and five padding writes. When the image ends, or when the target's status lines say to stop, the block writes four startup bytes and reports a result code.

Payload bytes are passed through unchanged. The block writes at most one byte per clock and only while the port-ready input is high. If the source has no byte to offer, the block waits. The image is taken to end at the byte that carries `src_last`. If that byte falls partway through a chunk, the rest of the chunk is filled with 0xFF and a length error is reported. If the ready line stays low for too long after the program pulse, the block gives up and reports a timeout without writing anything.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset is released, `cfg_prog_n` stays low through the first PULSE_CLKS rising clock edges. It goes high at the PULSE_CLKS-th edge and stays high from then on.
- R2: No write strobe occurs while `cfg_prog_n` is low, or before `cfg_init_ok` has been seen high after the program pulse.
- R3: The first eight writes are, in this order: 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B.
- R4: Each frame is written in this order:
  - the start code 0x4F;
  - 21 payload bytes, in source order and unchanged;
  - the check code 0x4B;
  - the five padding writes 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R5: A frame begins only while `cfg_init_ok` is high, `cfg_done` is low and the byte flagged `src_last` has not yet been taken. Otherwise the block moves to the startup bytes.
- R6: After the last frame, exactly four 0xFF bytes are written. After that `fin` goes high and stays high with a stable `err_code` and no further strobes.
- R7: `err_code` is 0 (success) when `cfg_done` is high at the last startup write and the last payload byte was taken. Otherwise it is 1 (failure), unless R8 or R10 applies.
- R8: If `cfg_init_ok` stays low for WAIT_LIMIT cycles after the program pulse, `fin` rises with `err_code` 2 and no byte is written.
- R9: `cfg_wr_stb` and `src_ready` are high only while `cfg_port_rdy` is high. A payload byte is written only in a cycle where `src_valid` and `src_ready` are both high.
- R10: If `src_last` arrives before the 21st byte of a frame, the frame is filled up to 21 bytes with 0xFF and `err_code` becomes 3. This takes priority over codes 0 and 1.
- R11: During reset: `cfg_prog_n` is low, and `cfg_wr_stb`, `src_ready` and `fin` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_prog_n | output | 1 | Active-low program line to the target |
| cfg_init_ok | input | 1 | High when the target is ready to accept configuration |
| cfg_done | input | 1 | High when the target reports configuration complete |
| cfg_port_rdy | input | 1 | Write port can accept a byte this cycle |
| cfg_wr_stb | output | 1 | One-cycle write strobe per byte |
| cfg_wr_data | output | 8 | Byte being written |
| src_data | input | 8 | Payload byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_last | input | 1 | Source byte is the final payload byte |
| src_ready | output | 1 | Block takes the source byte this cycle |
| fin | output | 1 | Sequence finished (sticky until reset) |
| err_code | output | 2 | 0 success, 1 failure, 2 ready timeout, 3 short final frame |

## Verification
The assertions check several rules on every cycle:
- no strobe or source-ready without port-ready;
- no strobe while the program line is low;
- each accepted payload byte appears unchanged on the write port in the same cycle;
- the program line never falls again once it has been released;
- after finishing, the block is quiet and holds its result code.

The byte order needs the bench's scenarios, because it is a property of the whole write stream. That covers the header and frame layout, padding of a short frame, the frame-start decision on the status lines, and the result code chosen at the end. The scenarios are a clean load, a load with port and source stalls, a short image, aborts on the ready and done lines, a load where done never rises, and a ready timeout.

// File: rtl/cfgs_pkg.sv
`timescale 1ns/100ps
package cfgs_pkg;

    typedef enum logic [2:0] {
        PH_PROG,
        PH_WAIT,
        PH_HDR,
        PH_PRE,
        PH_PAY,
        PH_TAIL,
        PH_START,
        PH_FIN
    } phase_e;

    localparam logic [7:0] BYTE_FILL = 8'hFF;
    localparam logic [7:0] BYTE_SOF  = 8'h4F;
    localparam logic [7:0] BYTE_CHK  = 8'h4B;

    localparam int HDR_LEN   = 8;
    localparam int TAIL_LEN  = 6;
    localparam int START_LEN = 4;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_FAIL = 2'd1;
    localparam logic [1:0] ERR_TMO  = 2'd2;
    localparam logic [1:0] ERR_LEN  = 2'd3;

    // Header: three fill bytes (the first is a throwaway), start code,
    // a fixed length field the target ignores, then the check code.
    function automatic logic [7:0] hdr_byte(input logic [2:0] i);
        case (i)
            3'd3:    hdr_byte = BYTE_SOF;
            3'd4:    hdr_byte = 8'h80;
            3'd5:    hdr_byte = 8'hAF;
            3'd6:    hdr_byte = 8'h9B;
            3'd7:    hdr_byte = BYTE_CHK;
            default: hdr_byte = BYTE_FILL;
        endcase
    endfunction

    // Frame trailer: check code, then five padding writes.
    function automatic logic [7:0] tail_byte(input logic [2:0] i);
        case (i)
            3'd0, 3'd2: tail_byte = BYTE_CHK;
            default:    tail_byte = BYTE_FILL;
        endcase
    endfunction

endpackage

// File: rtl/cfgs_byte_mux.sv
`timescale 1ns/100ps
module cfgs_byte_mux
    import cfgs_pkg::*;
(
    input  phase_e     ph,
    input  logic [2:0] idx,
    input  logic       pad,
    input  logic [7:0] src_data,
    output logic [7:0] wr_data
);

    always_comb begin
        case (ph)
            PH_HDR:  wr_data = hdr_byte(idx);
            PH_PRE:  wr_data = BYTE_SOF;
            PH_PAY:  wr_data = pad ? BYTE_FILL : src_data;
            PH_TAIL: wr_data = tail_byte(idx);
            default: wr_data = BYTE_FILL;
        endcase
    end

endmodule

// File: rtl/cfgs_seq_ctrl.sv
`timescale 1ns/100ps
module cfgs_seq_ctrl
    import cfgs_pkg::*;
#(
    parameter int PULSE_CLKS  = 2500,
    parameter int WAIT_LIMIT  = 1000000,
    parameter int FRAME_BYTES = 21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_ok,
    input  logic       done_in,
    input  logic       port_rdy,
    input  logic       src_valid,
    input  logic       src_last,
    output phase_e     ph,
    output logic [2:0] idx,
    output logic       pad,
    output logic       wr_stb,
    output logic       src_ready,
    output logic [1:0] code
);

    localparam int MAX_A = (PULSE_CLKS > WAIT_LIMIT) ? PULSE_CLKS : WAIT_LIMIT;
    localparam int MAX_C = (MAX_A > FRAME_BYTES) ? MAX_A : FRAME_BYTES;
    localparam int CW_R  = $clog2(MAX_C + 1);
    localparam int CW    = (CW_R < 4) ? 4 : CW_R;

    localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CLKS - 1);
    localparam logic [CW-1:0] WAIT_END  = CW'(WAIT_LIMIT - 1);
    localparam logic [CW-1:0] FRM_END   = CW'(FRAME_BYTES - 1);
    localparam logic [CW-1:0] HDR_END   = CW'(HDR_LEN - 1);
    localparam logic [CW-1:0] TAIL_END  = CW'(TAIL_LEN - 1);
    localparam logic [CW-1:0] START_END = CW'(START_LEN - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          pad;
        logic          seen_last;
        logic          len_err;
        logic [1:0]    code;
    } ctl_t;

    ctl_t st_d, st_q;
    logic stb_d;
    logic rdy_d;

    always_comb begin
        st_d  = st_q;
        stb_d = 1'b0;
        rdy_d = (st_q.ph == PH_PAY) && !st_q.pad && port_rdy;
        case (st_q.ph)
            PH_PROG: begin
                if (st_q.cnt == PULSE_END) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (init_ok) begin
                    st_d.ph  = PH_HDR;
                    st_d.cnt = '0;
                end else if (st_q.cnt == WAIT_END) begin
                    st_d.ph   = PH_FIN;
                    st_d.code = ERR_TMO;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_HDR: begin
                if (port_rdy) begin
                    stb_d = 1'b1;
                    if (st_q.cnt == HDR_END) begin
                        st_d.ph  = PH_PRE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_PRE: begin
                // Frame-start decision: ready high, done low, image not ended.
                if (init_ok && !done_in && !st_q.seen_last) begin
                    if (port_rdy) begin
                        stb_d    = 1'b1;
                        st_d.ph  = PH_PAY;
                        st_d.cnt = '0;
                    end
                end else begin
                    st_d.ph  = PH_START;
                    st_d.cnt = '0;
                end
            end
            PH_PAY: begin
                if (st_q.pad) begin
                    stb_d = port_rdy;
                end else if (rdy_d && src_valid) begin
                    stb_d = 1'b1;
                    if (src_last) begin
                        st_d.seen_last = 1'b1;
                        if (st_q.cnt != FRM_END) begin
                            st_d.pad     = 1'b1;
                            st_d.len_err = 1'b1;
                        end
                    end
                end
                if (stb_d) begin
                    if (st_q.cnt == FRM_END) begin
                        st_d.ph  = PH_TAIL;
                        st_d.cnt = '0;
                        st_d.pad = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                if (port_rdy) begin
                    stb_d = 1'b1;
                    if (st_q.cnt == TAIL_END) begin
                        st_d.ph  = PH_PRE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_START: begin
                if (port_rdy) begin
                    stb_d = 1'b1;
                    if (st_q.cnt == START_END) begin
                        st_d.ph = PH_FIN;
                        if (st_q.len_err)
                            st_d.code = ERR_LEN;
                        else if (done_in && st_q.seen_last)
                            st_d.code = ERR_NONE;
                        else
                            st_d.code = ERR_FAIL;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_PROG, cnt: '0, pad: 1'b0, seen_last: 1'b0,
                      len_err: 1'b0, code: ERR_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign ph        = st_q.ph;
    assign idx       = st_q.cnt[2:0];
    assign pad       = st_q.pad;
    assign wr_stb    = stb_d;
    assign src_ready = rdy_d;
    assign code      = st_q.code;

endmodule

// File: rtl/cfg_stream_loader.sv
`timescale 1ns/100ps
module cfg_stream_loader
    import cfgs_pkg::*;
#(
    parameter int PULSE_CLKS  = 2500,
    parameter int WAIT_LIMIT  = 1000000,
    parameter int FRAME_BYTES = 21
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       cfg_prog_n,
    input  logic       cfg_init_ok,
    input  logic       cfg_done,
    input  logic       cfg_port_rdy,
    output logic       cfg_wr_stb,
    output logic [7:0] cfg_wr_data,
    input  logic [7:0] src_data,
    input  logic       src_valid,
    input  logic       src_last,
    output logic       src_ready,
    output logic       fin,
    output logic [1:0] err_code
);

    phase_e     ph;
    logic [2:0] idx;
    logic       pad;

    cfgs_seq_ctrl #(
        .PULSE_CLKS (PULSE_CLKS),
        .WAIT_LIMIT (WAIT_LIMIT),
        .FRAME_BYTES(FRAME_BYTES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_ok  (cfg_init_ok),
        .done_in  (cfg_done),
        .port_rdy (cfg_port_rdy),
        .src_valid(src_valid),
        .src_last (src_last),
        .ph       (ph),
        .idx      (idx),
        .pad      (pad),
        .wr_stb   (cfg_wr_stb),
        .src_ready(src_ready),
        .code     (err_code)
    );

    cfgs_byte_mux u_mux (
        .ph      (ph),
        .idx     (idx),
        .pad     (pad),
        .src_data(src_data),
        .wr_data (cfg_wr_data)
    );

    assign cfg_prog_n = (ph != PH_PROG);
    assign fin        = (ph == PH_FIN);

endmodule

// File: rtl/cfgs_loader_chk.sv
`timescale 1ns/100ps
module cfgs_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_prog_n,
    input logic       cfg_port_rdy,
    input logic       cfg_wr_stb,
    input logic [7:0] cfg_wr_data,
    input logic [7:0] src_data,
    input logic       src_valid,
    input logic       src_ready,
    input logic       fin,
    input logic [1:0] err_code
);

    p_stb_needs_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_stb |-> cfg_port_rdy);

    p_take_needs_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> cfg_port_rdy);

    p_no_stb_in_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> !cfg_wr_stb);

    p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && src_valid) |-> (cfg_wr_stb && cfg_wr_data == src_data));

    p_prog_stays_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog_n |=> cfg_prog_n);

    p_fin_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (fin && $stable(err_code)));

    p_fin_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (!cfg_wr_stb && !src_ready));

endmodule

bind cfg_stream_loader cfgs_loader_chk u_chk (.*);

// File: tb/tb_cfg_stream_loader.sv
`timescale 1ns/100ps
module tb_cfg_stream_loader;

    localparam int PULSE_T = 8;
    localparam int WAIT_T  = 60;
    localparam int FRM     = 21;
    localparam int LOGMAX  = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_init_ok = 1'b0;
    logic       cfg_done = 1'b0;
    logic       cfg_port_rdy = 1'b1;
    logic       src_valid = 1'b0;
    logic [7:0] src_data;
    logic       src_last;
    logic       cfg_prog_n, cfg_wr_stb, src_ready, fin;
    logic [7:0] cfg_wr_data;
    logic [1:0] err_code;

    int n_chk = 0, n_fail = 0;
    int plen = 0, idx = 0, cyc = 0;
    int rise_at = 0, drop_at = -1, done_at = -1, auto_done = 0, stress = 0;
    int dropped = 0, init_seen = 0;
    int nlog = 0, nexp = 0, stb_bad = 0, pre_init_wr = 0, prog_low = 0;
    logic [7:0] log_q [LOGMAX];
    logic [7:0] exp_q [LOGMAX];

    always #2 clk = ~clk;

    cfg_stream_loader #(.PULSE_CLKS(PULSE_T), .WAIT_LIMIT(WAIT_T), .FRAME_BYTES(FRM)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_prog_n(cfg_prog_n), .cfg_init_ok(cfg_init_ok),
        .cfg_done(cfg_done), .cfg_port_rdy(cfg_port_rdy), .cfg_wr_stb(cfg_wr_stb),
        .cfg_wr_data(cfg_wr_data), .src_data(src_data), .src_valid(src_valid),
        .src_last(src_last), .src_ready(src_ready), .fin(fin), .err_code(err_code)
    );

    function automatic logic [7:0] pay_b(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    assign src_data = pay_b(idx);
    assign src_last = (idx == plen - 1);

    // Monitor samples at the falling edge; inputs change 1 ns after the rising edge.
    initial begin
        logic hs, last_hs;
        forever begin
            @(negedge clk);
            hs = 1'b0;
            last_hs = 1'b0;
            if (rst_n) begin
                if (!cfg_prog_n) prog_low++;
                if (cfg_wr_stb) begin
                    if (!cfg_port_rdy) stb_bad++;
                    if (init_seen == 0) pre_init_wr++;
                    if (nlog < LOGMAX) log_q[nlog] = cfg_wr_data;
                    nlog++;
                end
                hs = src_valid && src_ready;
                last_hs = hs && src_last;
                if (cfg_init_ok) init_seen = 1;
            end
            @(posedge clk);
            #1;
            if (rst_n) cyc++;
            if (hs) idx++;
            if (last_hs && auto_done != 0) cfg_done = 1'b1;
            if (done_at >= 0 && nlog >= done_at) cfg_done = 1'b1;
            if (drop_at >= 0 && nlog >= drop_at) dropped = 1;
            cfg_init_ok  = (cyc >= rise_at) && (dropped == 0);
            cfg_port_rdy = (stress != 0) ? ((cyc % 5) != 3) : 1'b1;
            src_valid    = (idx < plen) && ((stress != 0) ? ((cyc % 7) != 2) : 1'b1);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_run(input int pl, input int rise, input int drop, input int dn,
                             input int autod, input int str);
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        plen = pl; idx = 0; cyc = 0;
        rise_at = rise; drop_at = drop; done_at = dn; auto_done = autod; stress = str;
        dropped = 0; init_seen = 0; nlog = 0; stb_bad = 0; pre_init_wr = 0; prog_low = 0;
        cfg_done = 1'b0; cfg_init_ok = 1'b0; cfg_port_rdy = 1'b1; src_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        rst_n = 1'b1;
    endtask

    task automatic wait_fin(input string tag);
        int n = 0;
        while (!fin && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(fin == 1'b1, {tag, " fin reached (R6)"}, fin, 1);
        repeat (3) @(negedge clk);
        chk(fin == 1'b1 && cfg_wr_stb == 1'b0, {tag, " fin sticky/quiet (R6)"}, fin, 1);
    endtask

    task automatic build_exp(input int pl, input int frames);
        logic [7:0] hdr [8] = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
        logic [7:0] tl [6]  = '{8'h4B, 8'hFF, 8'h4B, 8'hFF, 8'hFF, 8'hFF};
        nexp = 0;
        for (int i = 0; i < 8; i++) begin exp_q[nexp] = hdr[i]; nexp++; end
        for (int f = 0; f < frames; f++) begin
            exp_q[nexp] = 8'h4F; nexp++;
            for (int b = 0; b < FRM; b++) begin
                exp_q[nexp] = ((f * FRM + b) < pl) ? pay_b(f * FRM + b) : 8'hFF;
                nexp++;
            end
            for (int i = 0; i < 6; i++) begin exp_q[nexp] = tl[i]; nexp++; end
        end
        for (int i = 0; i < 4; i++) begin exp_q[nexp] = 8'hFF; nexp++; end
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        chk(nlog == nexp, {tag, " write count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
        if (bad >= 0) chk(1'b0, {tag, " byte stream"}, int'(log_q[bad]), int'(exp_q[bad]));
        else          chk(1'b1, {tag, " byte stream"}, 0, 0);
    endtask

    task automatic t_reset();
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        @(negedge clk);
        chk(cfg_prog_n == 1'b0, "R11 prog_n in reset", cfg_prog_n, 0);
        chk(cfg_wr_stb == 1'b0 && src_ready == 1'b0 && fin == 1'b0,
            "R11 strobe/ready/fin in reset", cfg_wr_stb | src_ready | fin, 0);
    endtask

    task automatic t_clean();
        start_run(42, 20, -1, -1, 1, 0);
        wait_fin("clean");
        // Low samples fall between release and the PULSE_T-th edge: PULSE_T-1 falling edges.
        chk(prog_low == PULSE_T - 1, "R1 program pulse length", prog_low, PULSE_T - 1);
        chk(pre_init_wr == 0 && nlog > 0, "R2 no write before ready", pre_init_wr, 0);
        build_exp(42, 2);
        cmp_log("R3 R4 clean load");
        chk(err_code == 2'd0, "R7 success code", err_code, 0);
    endtask

    task automatic t_stall();
        start_run(63, 12, -1, -1, 1, 1);
        wait_fin("stall");
        chk(stb_bad == 0, "R9 strobe without port ready", stb_bad, 0);
        build_exp(63, 3);
        cmp_log("R9 R4 stalled load");
        chk(err_code == 2'd0, "R7 success after stalls", err_code, 0);
    endtask

    task automatic t_short();
        start_run(30, 12, -1, -1, 1, 0);
        wait_fin("short");
        build_exp(30, 2);
        cmp_log("R10 padded last frame");
        chk(err_code == 2'd3, "R10 length error code", err_code, 3);
    endtask

    task automatic t_drop_init();
        start_run(63, 12, 20, -1, 0, 0);
        wait_fin("drop");
        build_exp(63, 1);
        cmp_log("R5 ready dropped");
        chk(err_code == 2'd1, "R5 R7 failure after ready drop", err_code, 1);
    endtask

    task automatic t_early_done();
        start_run(63, 12, -1, 20, 0, 0);
        wait_fin("early");
        build_exp(63, 1);
        cmp_log("R5 done raised early");
        chk(err_code == 2'd1, "R7 failure with payload left", err_code, 1);
    endtask

    task automatic t_no_done();
        start_run(21, 12, -1, -1, 0, 0);
        wait_fin("nodone");
        build_exp(21, 1);
        cmp_log("R6 single frame");
        chk(err_code == 2'd1, "R7 failure when done stays low", err_code, 1);
    endtask

    task automatic t_timeout();
        start_run(21, 100000, -1, -1, 0, 0);
        wait_fin("timeout");
        chk(err_code == 2'd2, "R8 timeout code", err_code, 2);
        chk(nlog == 0, "R8 no writes on timeout", nlog, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_stall();
        t_short();
        t_drop_init();
        t_early_done();
        t_no_done();
        t_timeout();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule